// File: doc/BRIEF.md
# Supervisor Reset Pulse Generator

This block produces the single active-low reset that holds a processor in a known state. It watches three causes: a level flag from an external undervoltage comparator, an active-low push-button input, and a one-cycle fault pulse from a windowed watchdog. Any of them asserts the reset on the next clock. Once every cause has gone away, the reset is held for one full hold-off period before it releases. A cause that comes back during that period restarts the period from the beginning.

The button input is brought into the clock domain through two flops. It then has to stay low for a parameterised number of consecutive cycles before it counts, so short spikes are dropped and real presses are caught. The hold-off period is one of four nominal durations (1.4 ms, 28 ms, 200 ms, 1600 ms), chosen by parameter and scaled by the clock rate. A second parameter picks the pad style. In push-pull style the pad is always driven with the reset level. In open-drain style the pad is only ever driven low, and is released otherwise. A level flag, high while reset is asserted, is exported to keep the watchdog cleared.

Top module: `sup_reset_gen`

## Requirements
- R1: During the synchronous power-on reset (`rst_n` low) the reset is asserted. After `rst_n` rises with no cause present, it stays asserted for exactly HOLD clock edges and releases on the HOLD-th edge.
- R2: A high undervoltage flag sampled at a clock edge asserts the reset right after that edge. The reset stays asserted while the flag is high.
- R3: When the last edge that sampled a cause is E, the reset releases on edge E+HOLD and stays released while no cause is present.
- R4: A single-cycle watchdog fault pulse gives a reset of exactly HOLD cycles, measured from the edge that sampled it.
- R5: A cause sampled while the hold-off is running reloads it, so the release comes HOLD edges after that later cause.
- R6: A button-low pulse that lasts fewer than GLITCH_CYC cycles has no effect on the reset.
- R7: A button held low asserts the reset GLITCH_CYC+3 edges after the first edge that samples it low. This delay is two synchronizer flops, GLITCH_CYC counting cycles and the hold-off register.
- R8: After the button returns high, the reset stays asserted for HOLD+2 edges: the button is seen through the synchronizer and filter, then the full hold-off runs.
- R9: In push-pull style (DRV_STYLE = DRV_PUSH_PULL), `rst_oe_o` is 1 and `rst_n_o` is the inverse of `rst_active_o`.
- R10: In open-drain style (DRV_STYLE = DRV_OPEN_DRAIN), `rst_n_o` is 0 and `rst_oe_o` equals `rst_active_o`, so the pad is driven low only while reset is asserted.
- R11: `rst_active_o` is 1 exactly while the processor reset is asserted.
- R12: HOLD equals T_SEL × CLK_KHZ / 10 cycles. T_SEL is 14, 280, 2000 or 16000 for TMO_SEL 0, 1, 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous power-on reset, active low |
| uv_flag_i | input | 1 | Undervoltage flag from the comparator, high = supply low |
| mr_btn_n_i | input | 1 | Asynchronous push-button input, low = reset request |
| wdt_fault_i | input | 1 | One-cycle watchdog fault pulse |
| rst_active_o | output | 1 | High while the processor reset is asserted |
| rst_n_o | output | 1 | Pad data value for the active-low reset |
| rst_oe_o | output | 1 | Pad output enable |

## Verification
A hold-off counter that loads the wrong value, or that misses a reload, shows up as a release edge moved away from E+HOLD. The bench therefore samples the reset on the edge just before the expected release and on the release edge itself, which finds an error of one cycle. A filter count that is off by one either passes a pulse GLITCH_CYC-1 cycles long or delays a genuine press by one more edge, and both show up within GLITCH_CYC+3 cycles. A wrong pad style shows at once on the data and enable pins, because each check compares them with the active flag.

// File: rtl/sup_reset_pkg.sv
package sup_reset_pkg;

   typedef enum logic {
      DRV_PUSH_PULL  = 1'b0,
      DRV_OPEN_DRAIN = 1'b1
   } drv_style_e;

   // Nominal hold-off in tenths of a millisecond for each selector value.
   function automatic longint unsigned hold_tenths_ms(input int sel);
      case (sel)
         0:       return 64'd14;
         1:       return 64'd280;
         2:       return 64'd2000;
         default: return 64'd16000;
      endcase
   endfunction

   // Clock cycles for the selected hold-off at a given clock rate in kHz.
   function automatic int unsigned hold_cycles(input int sel, input longint unsigned clk_khz);
      longint unsigned cyc;
      cyc = (hold_tenths_ms(sel) * clk_khz) / 64'd10;
      return int'(cyc);
   endfunction

endpackage

// File: rtl/sup_reset_mr_filter.sv
module sup_reset_mr_filter #(
   parameter int unsigned GLITCH_CYC = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic btn_n_i,
   output logic hit_o
);

   localparam int unsigned GW = $clog2(GLITCH_CYC + 1);
   localparam logic [GW-1:0] GLITCH_V = GW'(GLITCH_CYC);

   if (GLITCH_CYC < 1) begin : g_bad_glitch
      $error("GLITCH_CYC must be at least 1");
   end

   logic          sync1_q;
   logic          sync2_q;
   logic [GW-1:0] low_cnt_q;

   // Two-flop synchronizer; idle level is high (button released).
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync1_q <= 1'b1;
         sync2_q <= 1'b1;
      end else begin
         sync1_q <= btn_n_i;
         sync2_q <= sync1_q;
      end
   end

   // Consecutive-low counter, saturating at the glitch length.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         low_cnt_q <= '0;
      end else if (sync2_q) begin
         low_cnt_q <= '0;
      end else if (low_cnt_q != GLITCH_V) begin
         low_cnt_q <= low_cnt_q + GW'(1);
      end
   end

   assign hit_o = (low_cnt_q == GLITCH_V);

endmodule

// File: rtl/sup_reset_holdoff.sv
module sup_reset_holdoff #(
   parameter int unsigned HOLD_CYC = 350000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cause_i,
   output logic active_o
);

   localparam int unsigned CW = $clog2(HOLD_CYC + 1);
   localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYC);

   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("HOLD_CYC must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic          active_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b1;
         cnt_q    <= HOLD_V;
      end else if (cause_i) begin
         active_q <= 1'b1;
         cnt_q    <= HOLD_V;
      end else if (active_q) begin
         if (cnt_q == CW'(1)) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
         end else begin
            cnt_q <= cnt_q - CW'(1);
         end
      end
   end

   assign active_o = active_q;

endmodule

// File: rtl/sup_reset_out_drv.sv
module sup_reset_out_drv
   import sup_reset_pkg::*;
#(
   parameter drv_style_e DRV_STYLE = DRV_PUSH_PULL
) (
   input  logic active_i,
   output logic pad_o,
   output logic oe_o
);

   if (DRV_STYLE == DRV_OPEN_DRAIN) begin : g_open_drain
      assign pad_o = 1'b0;
      assign oe_o  = active_i;
   end else begin : g_push_pull
      assign pad_o = ~active_i;
      assign oe_o  = 1'b1;
   end

endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen
   import sup_reset_pkg::*;
#(
   parameter longint unsigned CLK_KHZ    = 250000,
   parameter int              TMO_SEL    = 2,
   parameter int unsigned     GLITCH_CYC = 50,
   parameter drv_style_e      DRV_STYLE  = DRV_PUSH_PULL
) (
   input  logic clk,
   input  logic rst_n,
   input  logic uv_flag_i,
   input  logic mr_btn_n_i,
   input  logic wdt_fault_i,
   output logic rst_active_o,
   output logic rst_n_o,
   output logic rst_oe_o
);

   localparam int unsigned HOLD_CYC = hold_cycles(TMO_SEL, CLK_KHZ);

   if (TMO_SEL < 0 || TMO_SEL > 3) begin : g_bad_sel
      $error("TMO_SEL must be 0..3");
   end
   if (CLK_KHZ < 1) begin : g_bad_clk
      $error("CLK_KHZ must be positive");
   end

   logic mr_hit;
   logic any_cause;
   logic active;

   sup_reset_mr_filter #(
      .GLITCH_CYC(GLITCH_CYC)
   ) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .btn_n_i(mr_btn_n_i),
      .hit_o  (mr_hit)
   );

   assign any_cause = uv_flag_i | mr_hit | wdt_fault_i;

   sup_reset_holdoff #(
      .HOLD_CYC(HOLD_CYC)
   ) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .cause_i (any_cause),
      .active_o(active)
   );

   sup_reset_out_drv #(
      .DRV_STYLE(DRV_STYLE)
   ) u_drv (
      .active_i(active),
      .pad_o   (rst_n_o),
      .oe_o    (rst_oe_o)
   );

   assign rst_active_o = active;

endmodule

// File: rtl/sup_reset_gen_chk.sv
module sup_reset_gen_chk
   import sup_reset_pkg::*;
#(
   parameter int unsigned HOLD_CYC  = 1,
   parameter drv_style_e  DRV_STYLE = DRV_PUSH_PULL
) (
   input logic clk,
   input logic rst_n,
   input logic uv_flag_i,
   input logic wdt_fault_i,
   input logic mr_hit,
   input logic rst_active_o,
   input logic rst_n_o,
   input logic rst_oe_o
);

   logic        cause;
   logic [31:0] quiet_q;

   assign cause = uv_flag_i | wdt_fault_i | mr_hit;

   // Edges since the last sampled cause, saturating at HOLD_CYC.
   always_ff @(posedge clk) begin
      if (!rst_n || cause) begin
         quiet_q <= '0;
      end else if (quiet_q != HOLD_CYC) begin
         quiet_q <= quiet_q + 32'd1;
      end
   end

   AST_UV_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
      uv_flag_i |=> rst_active_o);  // R2

   AST_WDT_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_fault_i |=> rst_active_o);  // R4

   AST_MR_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
      mr_hit |=> rst_active_o);  // R7

   AST_FULL_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_active_o) |-> (quiet_q == HOLD_CYC));  // R3

   AST_HOLD_TILL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet_q < HOLD_CYC) |-> rst_active_o);  // R5

   if (DRV_STYLE == DRV_OPEN_DRAIN) begin : g_chk_od
      AST_OD_FORM: assert property (@(posedge clk) disable iff (!rst_n)
         (!rst_n_o) && (rst_oe_o == rst_active_o));  // R10
   end else begin : g_chk_pp
      AST_PP_FORM: assert property (@(posedge clk) disable iff (!rst_n)
         rst_oe_o && (rst_n_o == !rst_active_o));  // R9
   end

endmodule

bind sup_reset_gen sup_reset_gen_chk #(
   .HOLD_CYC (HOLD_CYC),
   .DRV_STYLE(DRV_STYLE)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .uv_flag_i   (uv_flag_i),
   .wdt_fault_i (wdt_fault_i),
   .mr_hit      (mr_hit),
   .rst_active_o(rst_active_o),
   .rst_n_o     (rst_n_o),
   .rst_oe_o    (rst_oe_o)
);

// File: tb/sup_reset_gen_tb_top.sv
`timescale 1ns/1ps
module sup_reset_gen_tb_top;
   import sup_reset_pkg::*;

   localparam longint unsigned CLK_KHZ = 10;
   localparam int TMO_SEL = 0;
   localparam int G = 4;
   // R12: selector 0 -> 14 tenths of ms; 14 * 10 kHz / 10 = 14 cycles
   localparam int T = 14 * 10 / 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic uv = 1'b0;
   logic mr_n = 1'b1;
   logic wdt = 1'b0;

   logic act_pp, pad_pp, oe_pp;
   logic act_od, pad_od, oe_od;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   sup_reset_gen #(.CLK_KHZ(CLK_KHZ), .TMO_SEL(TMO_SEL), .GLITCH_CYC(G),
                   .DRV_STYLE(DRV_PUSH_PULL)) dut_i (
      .clk(clk), .rst_n(rst_n), .uv_flag_i(uv), .mr_btn_n_i(mr_n),
      .wdt_fault_i(wdt), .rst_active_o(act_pp), .rst_n_o(pad_pp), .rst_oe_o(oe_pp));

   sup_reset_gen #(.CLK_KHZ(CLK_KHZ), .TMO_SEL(TMO_SEL), .GLITCH_CYC(G),
                   .DRV_STYLE(DRV_OPEN_DRAIN)) dut_od_i (
      .clk(clk), .rst_n(rst_n), .uv_flag_i(uv), .mr_btn_n_i(mr_n),
      .wdt_fault_i(wdt), .rst_active_o(act_od), .rst_n_o(pad_od), .rst_oe_o(oe_od));

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // Checks the active flag on both instances and both pad styles.
   task automatic expect_rst(input string req, input logic exp);
      chk(req, act_pp, exp);
      chk({req, " R11 open-drain flag"}, act_od, exp);
      chk("R9 push-pull data", pad_pp, ~exp);
      chk("R9 push-pull enable", oe_pp, 1'b1);
      chk("R10 open-drain data", pad_od, 1'b0);
      chk("R10 open-drain enable", oe_od, exp);
   endtask

   task automatic t_power_on();
      rst_n = 1'b0;
      tick(3);
      expect_rst("R1 during reset", 1'b1);
      rst_n = 1'b1;
      tick(T - 1);
      expect_rst("R1 R12 last held edge", 1'b1);
      tick(1);
      expect_rst("R1 R12 release edge", 1'b0);
   endtask

   task automatic t_uv_level();
      uv = 1'b1;
      tick(1);
      expect_rst("R2 assert next edge", 1'b1);
      tick(10);
      expect_rst("R2 held while high", 1'b1);
      uv = 1'b0;
      tick(T - 1);
      expect_rst("R3 still held", 1'b1);
      tick(1);
      expect_rst("R3 release", 1'b0);
      tick(20);
      expect_rst("R3 stays released", 1'b0);
   endtask

   task automatic t_wdt_pulse();
      wdt = 1'b1;
      tick(1);
      wdt = 1'b0;
      expect_rst("R4 asserted", 1'b1);
      tick(T - 1);
      expect_rst("R4 held full period", 1'b1);
      tick(1);
      expect_rst("R4 released", 1'b0);
   endtask

   task automatic t_reload();
      wdt = 1'b1;
      tick(1);
      wdt = 1'b0;
      tick(5);
      expect_rst("R5 mid hold-off", 1'b1);
      wdt = 1'b1;
      tick(1);
      wdt = 1'b0;
      tick(T - 1);
      expect_rst("R5 reloaded", 1'b1);
      tick(1);
      expect_rst("R5 release after reload", 1'b0);
   endtask

   task automatic t_mr_glitch();
      mr_n = 1'b0;
      tick(G - 1);
      mr_n = 1'b1;
      for (int i = 0; i < G + 6; i++) begin
         tick(1);
         chk("R6 short press ignored", act_pp, 1'b0);
      end
      mr_n = 1'b0;
      tick(1);
      mr_n = 1'b1;
      tick(G + 6);
      expect_rst("R6 one-cycle spike ignored", 1'b0);
   endtask

   task automatic t_mr_press();
      mr_n = 1'b0;
      tick(G + 2);
      expect_rst("R7 not yet", 1'b0);
      tick(1);
      expect_rst("R7 asserted", 1'b1);
      tick(5);
      mr_n = 1'b1;
      tick(T + 2);
      expect_rst("R8 held after release", 1'b1);
      tick(1);
      expect_rst("R8 released", 1'b0);
   endtask

   initial begin : main
      t_power_on();
      t_uv_level();
      t_wdt_pulse();
      t_reload();
      t_mr_glitch();
      t_mr_press();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule